// File: doc/BRIEF.md
# Header Pattern Match Classifier

This block watches received Ethernet frames as a byte stream and judges the opening 64 bytes of each frame against sixteen-bit halfword patterns. Two groups of four sets can be programmed. Each set holds a pattern, a don't-care mask, a halfword offset into the 64-byte window and, for the first set of a group only, a less-than-or-equal compare mode. Two more detectors are fixed. They flag an IPv4 payload carried in Ethernet II framing or in 802.3 LLC/SNAP framing.

A port on the receive path feeds the block one byte per valid beat, with start and end markers. The block publishes every flag together on a one-cycle done pulse. The flags then hold until the next frame is judged. Logic outside the block turns the flags into forwarding actions. Software writes pattern settings one set at a time. The settings are global, and a write only affects frames that start after it.

Top module: `hdr_match_classifier`

## Requirements
- R1: Only bytes 0 to 63 of a frame are inspected. Beats after byte 63 have no effect on any flag, and the frame's done pulse follows byte 63 even if the frame is longer.
- R2: `res_done` is high for exactly one cycle, two clock edges after the last inspected beat is sampled (byte 63 or the end-of-packet beat, whichever comes first). Every result output changes only on that edge.
- R3: Each set compares the halfword made of byte `2*offset` (bits 15:8) and byte `2*offset+1` (bits 7:0) with its pattern. In equality mode it matches when all unmasked bits are equal.
- R4: A mask bit of 1 makes that bit position don't-care. A mask bit of 0 makes it significant.
- R5: Set 0 of each group with its compare bit set matches when (halfword AND NOT mask) is less than or equal to (pattern AND NOT mask), both taken as unsigned values.
- R6: Sets 1 to 3 always compare for equality, whatever value is written to their compare bit.
- R7: A set whose selected halfword did not fully arrive before end-of-packet reports no match, even with an all-ones mask.
- R8: `res_ip_eth2` is 1 when bytes 12 and 13 are 0x08 and 0x00.
- R9: `res_ip_snap` is 1 when all of the following hold:
  - bytes 12-13 read as a big-endian value of at most 1500;
  - bytes 14-19 are AA AA 03 00 00 00;
  - bytes 20-21 are 08 00.
- R10: A configuration write during a frame does not change that frame's result. It applies from the next start-of-packet.
- R11: A write with `cfg_we` high loads the pattern, mask, offset and compare bit into set `cfg_set` of group `cfg_group`. Result bit `res_match[g*4+s]` belongs to group g, set s.
- R12: Valid beats outside a frame (no start-of-packet seen, or window already closed) are ignored. A start-of-packet in the middle of a frame abandons that frame without a done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Byte beat valid |
| rx_sop | input | 1 | Beat is the first byte of a frame |
| rx_eop | input | 1 | Beat is the last byte of a frame |
| rx_data | input | 8 | Frame byte |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_group | input | 1 | Programmable group select |
| cfg_set | input | 2 | Set select within the group |
| cfg_pattern | input | 16 | Pattern value |
| cfg_mask | input | 16 | Don't-care mask, 1 = ignore bit |
| cfg_offset | input | 5 | Halfword index in the 64-byte window |
| cfg_le | input | 1 | Less-or-equal mode, honoured on set 0 only |
| res_done | output | 1 | One-cycle result strobe |
| res_match | output | 8 | Per-set match flags, bit g*4+s |
| res_ip_snap | output | 1 | IPv4 in LLC/SNAP framing |
| res_ip_eth2 | output | 1 | IPv4 in Ethernet II framing |

## Verification
The hardest case to reach from the ports is a configuration write that lands while a frame is being received. The old settings must still judge that frame. The bench forks a register write a few beats into a frame whose halfword matches the old pattern, and expects a match. It then sends the same bytes again and expects no match. Short frames that end between the two bytes of a selected halfword, and a frame whose last compared halfword sits at bytes 62 and 63 with trailing bytes beyond it, cover the window edges.

// File: rtl/hmc_pkg.sv
// Shared widths and the per-set configuration record for the header
// pattern match classifier.
package hmc_pkg;
    localparam int HW_W  = 16;          // compared halfword width
    localparam int OFF_W = 5;           // halfword offset width
    localparam int IDX_W = OFF_W + 1;   // byte index within the window

    typedef struct packed {
        logic [HW_W-1:0]  pattern;
        logic [HW_W-1:0]  mask;
        logic [OFF_W-1:0] offset;
        logic             le;
    } set_cfg_t;
endpackage

// File: rtl/hmc_byte_tracker.sv
// Byte position tracker. Numbers the beats of a frame inside the
// inspection window and raises a registered end-of-window pulse after the
// last inspected beat.
// Assumes: one byte per valid beat; rx_sop marks byte 0; the window is
// 2**IDX_W bytes long.
module hmc_byte_tracker #(
    parameter int IDX_W = hmc_pkg::IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic             rx_sop,
    input  logic             rx_eop,
    output logic             byte_hit,
    output logic             pkt_start,
    output logic [IDX_W-1:0] byte_idx,
    output logic             win_end
);
    logic             in_pkt;
    logic [IDX_W-1:0] next_idx;
    logic             last_beat;

    // Beat qualification and current index.
    always_comb begin
        byte_hit  = rx_valid && (rx_sop || in_pkt);
        pkt_start = rx_valid && rx_sop;
        byte_idx  = rx_sop ? '0 : next_idx;
        last_beat = (byte_idx == {IDX_W{1'b1}}) || rx_eop;
    end

    // Window state: open at start, close at byte 63 or end of packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_pkt   <= 1'b0;
            next_idx <= '0;
            win_end  <= 1'b0;
        end else begin
            win_end <= byte_hit && last_beat;
            if (byte_hit) begin
                in_pkt   <= !last_beat;
                next_idx <= byte_idx + 1'b1;
            end
        end
    end

    // R1
    // window_close_chk
    window_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_hit && byte_idx == {IDX_W{1'b1}}) |=> (!in_pkt && win_end));
endmodule

// File: rtl/hmc_cfg_bank.sv
// Configuration store. Holds a shadow copy of every programmable set,
// written by the register port, and an active copy reloaded at each
// start-of-packet. eff_cfg is what the beat in flight must use: the
// shadow on the start beat, the active copy otherwise.
// Assumes: a write in the same cycle as a start beat belongs to the
// following frame.
module hmc_cfg_bank
    import hmc_pkg::*;
#(
    parameter int GROUPS = 2,
    parameter int SETS   = 4,
    localparam int GSEL_W = (GROUPS > 1) ? $clog2(GROUPS) : 1,
    localparam int SSEL_W = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int N      = GROUPS * SETS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [GSEL_W-1:0]     cfg_group,
    input  logic [SSEL_W-1:0]     cfg_set,
    input  logic [HW_W-1:0]       cfg_pattern,
    input  logic [HW_W-1:0]       cfg_mask,
    input  logic [OFF_W-1:0]      cfg_offset,
    input  logic                  cfg_le,
    input  logic                  pkt_start,
    output set_cfg_t [N-1:0]      eff_cfg,
    output set_cfg_t [N-1:0]      act_cfg
);
    set_cfg_t [N-1:0] shadow;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        for (genvar s = 0; s < SETS; s++) begin : g_set
            localparam int K = g * SETS + s;
            wire sel = cfg_we && (cfg_group == GSEL_W'(g)) && (cfg_set == SSEL_W'(s));

            // Shadow register write; compare bit kept only on set 0.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    shadow[K] <= '0;
                end else if (sel) begin
                    shadow[K].pattern <= cfg_pattern;
                    shadow[K].mask    <= cfg_mask;
                    shadow[K].offset  <= cfg_offset;
                    shadow[K].le      <= (s == 0) ? cfg_le : 1'b0;
                end
            end

            // Active copy reload at start of frame.
            always_ff @(posedge clk) begin
                if (!rst_n) act_cfg[K] <= '0;
                else if (pkt_start) act_cfg[K] <= shadow[K];
            end

            assign eff_cfg[K] = pkt_start ? shadow[K] : act_cfg[K];

            // R10
            // cfg_hold_chk
            cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !pkt_start |=> $stable(act_cfg[K]));
        end
    end
endmodule

// File: rtl/hmc_pattern_set.sv
// One programmable pattern set. Captures the two bytes of its selected
// halfword and compares them, under mask, with its pattern. With LE_ABLE
// set, the compare bit selects an unsigned less-or-equal test.
// Assumes: eff_cfg is stable for the beat in flight; act_cfg holds the
// frame's settings until the next start beat.
module hmc_pattern_set
    import hmc_pkg::*;
#(
    parameter bit LE_ABLE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_hit,
    input  logic             pkt_start,
    input  logic [IDX_W-1:0] byte_idx,
    input  logic [7:0]       rx_data,
    input  set_cfg_t         eff_cfg,
    input  set_cfg_t         act_cfg,
    output logic             match
);
    logic [7:0]      hi_q, lo_q;
    logic            got_hi, got_lo;
    logic            hit_hi, hit_lo;
    logic [HW_W-1:0] care, hw;
    logic            eq_ok, le_ok;

    // Halfword byte position decode.
    always_comb begin
        hit_hi = byte_hit && (byte_idx == {eff_cfg.offset, 1'b0});
        hit_lo = byte_hit && (byte_idx == {eff_cfg.offset, 1'b1});
    end

    // Byte capture and arrival flags, cleared at each start beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q   <= '0;
            lo_q   <= '0;
            got_hi <= 1'b0;
            got_lo <= 1'b0;
        end else begin
            if (pkt_start) begin
                got_hi <= hit_hi;
                got_lo <= 1'b0;
            end else begin
                if (hit_hi) got_hi <= 1'b1;
                if (hit_lo) got_lo <= 1'b1;
            end
            if (hit_hi) hi_q <= rx_data;
            if (hit_lo) lo_q <= rx_data;
        end
    end

    // Masked comparison against the frame's settings.
    always_comb begin
        care  = ~act_cfg.mask;
        hw    = {hi_q, lo_q};
        eq_ok = ((hw ^ act_cfg.pattern) & care) == '0;
        le_ok = (hw & care) <= (act_cfg.pattern & care);
    end

    if (LE_ABLE) begin : g_le
        assign match = got_hi && got_lo && (act_cfg.le ? le_ok : eq_ok);
    end else begin : g_eq
        assign match = got_hi && got_lo && eq_ok;
    end

    // R7
    // hw_order_chk
    hw_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(got_lo) |-> got_hi);
endmodule

// File: rtl/hmc_ip_detect.sv
// Fixed detectors for IPv4 carried in Ethernet II and in LLC/SNAP framing.
// Captures bytes 12 to 21 of the frame and tests them against constants.
// Assumes: same beat qualification as the programmable sets.
module hmc_ip_detect
    import hmc_pkg::*;
#(
    parameter int FIRST_BYTE = 12,
    parameter int NBYTES     = 10,
    parameter logic [15:0] IP_TYPE = 16'h0800,
    parameter int LEN_LIMIT  = 1500,
    parameter logic [47:0] SNAP_HDR = 48'hAAAA_0300_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_hit,
    input  logic             pkt_start,
    input  logic [IDX_W-1:0] byte_idx,
    input  logic [7:0]       rx_data,
    output logic             ip_eth2,
    output logic             ip_snap
);
    logic [7:0]        hb [NBYTES];
    logic [NBYTES-1:0] got;

    for (genvar k = 0; k < NBYTES; k++) begin : g_cap
        wire hit = byte_hit && (byte_idx == IDX_W'(FIRST_BYTE + k));
        // Capture one header byte; arrival flag cleared at start.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hb[k]  <= '0;
                got[k] <= 1'b0;
            end else begin
                if (pkt_start) got[k] <= hit;
                else if (hit)  got[k] <= 1'b1;
                if (hit) hb[k] <= rx_data;
            end
        end
    end

    // Constant comparisons on the captured header fields.
    always_comb begin
        ip_eth2 = got[0] && got[1] && ({hb[0], hb[1]} == IP_TYPE);
        ip_snap = (&got) && ({hb[0], hb[1]} <= 16'(LEN_LIMIT))
               && ({hb[2], hb[3], hb[4], hb[5], hb[6], hb[7]} == SNAP_HDR)
               && ({hb[8], hb[9]} == IP_TYPE);
    end

    // R9
    // frame_kind_excl_chk
    frame_kind_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ip_eth2 && ip_snap));
endmodule

// File: rtl/hdr_match_classifier.sv
// Header pattern match classifier top. Numbers incoming beats, feeds the
// programmable sets and fixed IP detectors, and latches all flags on one
// done pulse per frame.
// Assumes: byte stream with start/end markers; settings global to all
// frames; results held until the next done.
module hdr_match_classifier
    import hmc_pkg::*;
#(
    parameter int PROG_GROUPS = 2,
    parameter int SETS        = 4,
    localparam int GSEL_W = (PROG_GROUPS > 1) ? $clog2(PROG_GROUPS) : 1,
    localparam int SSEL_W = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int N      = PROG_GROUPS * SETS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic              rx_sop,
    input  logic              rx_eop,
    input  logic [7:0]        rx_data,
    input  logic              cfg_we,
    input  logic [GSEL_W-1:0] cfg_group,
    input  logic [SSEL_W-1:0] cfg_set,
    input  logic [HW_W-1:0]   cfg_pattern,
    input  logic [HW_W-1:0]   cfg_mask,
    input  logic [OFF_W-1:0]  cfg_offset,
    input  logic              cfg_le,
    output logic              res_done,
    output logic [N-1:0]      res_match,
    output logic              res_ip_snap,
    output logic              res_ip_eth2
);
    logic             byte_hit, pkt_start, win_end;
    logic [IDX_W-1:0] byte_idx;
    set_cfg_t [N-1:0] eff_cfg, act_cfg;
    logic [N-1:0]     match;
    logic             ip_eth2, ip_snap;

    hmc_byte_tracker #(.IDX_W(IDX_W)) u_track (
        .clk, .rst_n, .rx_valid, .rx_sop, .rx_eop,
        .byte_hit, .pkt_start, .byte_idx, .win_end
    );

    hmc_cfg_bank #(.GROUPS(PROG_GROUPS), .SETS(SETS)) u_cfg (
        .clk, .rst_n, .cfg_we, .cfg_group, .cfg_set, .cfg_pattern,
        .cfg_mask, .cfg_offset, .cfg_le, .pkt_start, .eff_cfg, .act_cfg
    );

    for (genvar k = 0; k < N; k++) begin : g_set
        hmc_pattern_set #(.LE_ABLE((k % SETS) == 0)) u_set (
            .clk, .rst_n, .byte_hit, .pkt_start, .byte_idx, .rx_data,
            .eff_cfg(eff_cfg[k]), .act_cfg(act_cfg[k]), .match(match[k])
        );
    end

    hmc_ip_detect u_ip (
        .clk, .rst_n, .byte_hit, .pkt_start, .byte_idx, .rx_data,
        .ip_eth2, .ip_snap
    );

    // Result latch and done strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_done    <= 1'b0;
            res_match   <= '0;
            res_ip_snap <= 1'b0;
            res_ip_eth2 <= 1'b0;
        end else begin
            res_done <= win_end;
            if (win_end) begin
                res_match   <= match;
                res_ip_snap <= ip_snap;
                res_ip_eth2 <= ip_eth2;
            end
        end
    end

    // R2
    // result_hold_chk
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_done |-> $stable({res_match, res_ip_snap, res_ip_eth2}));
endmodule

// File: tb/hdr_match_classifier_tb.sv
module hdr_match_classifier_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        cfg_we = 1'b0;
    logic [0:0]  cfg_group = '0;
    logic [1:0]  cfg_set = '0;
    logic [15:0] cfg_pattern = '0, cfg_mask = '0;
    logic [4:0]  cfg_offset = '0;
    logic        cfg_le = 1'b0;
    logic        res_done, res_ip_snap, res_ip_eth2;
    logic [7:0]  res_match;

    hdr_match_classifier u_dut (
        .clk, .rst_n, .rx_valid, .rx_sop, .rx_eop, .rx_data,
        .cfg_we, .cfg_group, .cfg_set, .cfg_pattern, .cfg_mask,
        .cfg_offset, .cfg_le, .res_done, .res_match, .res_ip_snap,
        .res_ip_eth2
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, fails = 0;

    // bench-side configuration model, index g*4+s
    logic [15:0] m_pat [8];
    logic [15:0] m_msk [8];
    logic [4:0]  m_off [8];
    logic        m_le  [8];

    logic [7:0] pk [128];

    typedef struct {
        logic [7:0] mt;
        logic       snap;
        logic       eth2;
        int         due;
    } exp_t;
    exp_t  exp_q [$];
    string tag_q [$];

    task automatic cfg_write(input int g, input int s, input logic [15:0] pat,
                             input logic [15:0] msk, input logic [4:0] off,
                             input logic le);
        @(negedge clk);
        cfg_we = 1'b1; cfg_group = 1'(g); cfg_set = 2'(s);
        cfg_pattern = pat; cfg_mask = msk; cfg_offset = off; cfg_le = le;
        m_pat[g*4+s] = pat; m_msk[g*4+s] = msk; m_off[g*4+s] = off;
        m_le[g*4+s] = (s == 0) ? le : 1'b0;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic exp_t model(input int len);
        exp_t e;
        int win = (len < 64) ? len : 64;
        e.mt = '0;
        for (int k = 0; k < 8; k++) begin
            int hi = m_off[k] * 2;
            logic [15:0] hw, care;
            if (hi + 1 < win) begin
                hw = {pk[hi], pk[hi+1]};
                care = ~m_msk[k];
                if (m_le[k]) e.mt[k] = (hw & care) <= (m_pat[k] & care);
                else         e.mt[k] = ((hw ^ m_pat[k]) & care) == 16'h0;
            end
        end
        e.eth2 = (win >= 14) && pk[12] == 8'h08 && pk[13] == 8'h00;
        e.snap = (win >= 22) && ({pk[12], pk[13]} <= 16'd1500)
              && pk[14] == 8'hAA && pk[15] == 8'hAA && pk[16] == 8'h03
              && pk[17] == 8'h00 && pk[18] == 8'h00 && pk[19] == 8'h00
              && pk[20] == 8'h08 && pk[21] == 8'h00;
        e.due = 0;
        return e;
    endfunction

    task automatic fill(input int seed);
        for (int i = 0; i < 128; i++) pk[i] = 8'(i * 7 + seed);
    endtask

    // driver: pushes expected result, then streams the frame
    task automatic send(input string tag, input int len, input bit with_eop);
        exp_t e;
        int win = (len < 64) ? len : 64;
        e = model(len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (i == 0 && with_eop) begin
                e.due = cyc + win - 1 + 2;
                exp_q.push_back(e);
                tag_q.push_back(tag);
            end
            rx_valid = 1'b1; rx_sop = (i == 0);
            rx_eop = with_eop && (i == len - 1); rx_data = pk[i];
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0;
        end
    endtask

    task automatic stray(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sop = 1'b0; rx_eop = (i == n - 1);
            rx_data = 8'h08;
        end
    endtask

    // monitor: pops expected items on every done pulse
    always @(negedge clk) begin
        if (rst_n && res_done) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R12 unexpected done: got done=1 expected none");
            end else begin
                exp_t e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (res_match !== e.mt || res_ip_snap !== e.snap ||
                    res_ip_eth2 !== e.eth2 || cyc != e.due) begin
                    fails++;
                    $display("FAIL %s: got match=%h snap=%b eth2=%b cyc=%0d expected match=%h snap=%b eth2=%b cyc=%0d",
                             t, res_match, res_ip_snap, res_ip_eth2, cyc,
                             e.mt, e.snap, e.eth2, e.due);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got no finish expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < 8; k++) begin
            m_pat[k] = '0; m_msk[k] = '0; m_off[k] = '0; m_le[k] = 1'b0;
        end
        repeat (3) @(negedge clk);
        // R2 reset state
        checks++;
        if (res_done !== 1'b0 || res_match !== 8'h00 || res_ip_snap !== 1'b0 ||
            res_ip_eth2 !== 1'b0) begin
            fails++;
            $display("FAIL R2 reset: got done=%b match=%h expected done=0 match=00",
                     res_done, res_match);
        end
        rst_n = 1'b1;

        // R11 configuration of both groups
        cfg_write(0, 0, 16'h0100, 16'hF000, 5'd8, 1'b1);
        cfg_write(0, 1, 16'hABCD, 16'h0000, 5'd3, 1'b0);
        cfg_write(0, 2, 16'hCDAB, 16'h0000, 5'd3, 1'b0);
        cfg_write(0, 3, 16'h0100, 16'h0000, 5'd8, 1'b1); // R6 compare bit ignored
        cfg_write(1, 0, 16'h0800, 16'h0000, 5'd6, 1'b0);
        cfg_write(1, 1, 16'h5566, 16'h0000, 5'd31, 1'b0);
        cfg_write(1, 2, 16'h1200, 16'h00FF, 5'd5, 1'b0);
        cfg_write(1, 3, 16'h0000, 16'hFFFF, 5'd3, 1'b0);

        fill(1); pk[6] = 8'hAB; pk[7] = 8'hCD;
        send("R3 byte order equality", 40, 1); idle(3);
        fill(2); pk[10] = 8'h12; pk[11] = 8'h77;
        send("R4 R11 masked low byte", 40, 1); idle(3);
        fill(3); pk[16] = 8'h00; pk[17] = 8'hFF;
        send("R5 below pattern", 40, 1); idle(2);
        fill(3); pk[16] = 8'h01; pk[17] = 8'h00;
        send("R5 R6 equal pattern", 40, 1); idle(2);
        fill(3); pk[16] = 8'h01; pk[17] = 8'h01;
        send("R5 above pattern", 40, 1); idle(2);
        fill(3); pk[16] = 8'hF0; pk[17] = 8'hFF;
        send("R5 R6 masked high nibble", 40, 1); idle(2);
        fill(4); pk[6] = 8'hAB;
        send("R7 short frame", 7, 1); idle(2);
        fill(5); pk[62] = 8'h55; pk[63] = 8'h66;
        send("R1 long frame last halfword", 100, 1); idle(3);
        fill(6); pk[12] = 8'h08; pk[13] = 8'h00;
        send("R8 ethernet ii ip", 60, 1); idle(2);
        fill(7); pk[12] = 8'h05; pk[13] = 8'hDC;
        pk[14] = 8'hAA; pk[15] = 8'hAA; pk[16] = 8'h03;
        pk[17] = 8'h00; pk[18] = 8'h00; pk[19] = 8'h00;
        pk[20] = 8'h08; pk[21] = 8'h00;
        send("R9 snap ip at limit", 60, 1); idle(2);
        pk[13] = 8'hDD;
        send("R9 snap length over limit", 60, 1); idle(2);
        pk[13] = 8'hDC; pk[21] = 8'h06;
        send("R9 snap other type", 60, 1); idle(2);

        // R10 write lands mid-frame
        fill(8); pk[6] = 8'hAB; pk[7] = 8'hCD;
        fork
            send("R10 old settings kept", 30, 1);
            begin
                repeat (5) @(negedge clk);
                cfg_write(0, 1, 16'h1111, 16'h0000, 5'd3, 1'b0);
            end
        join
        idle(2);
        send("R10 new settings used", 30, 1); idle(2);

        // R12 stray beats and an abandoned frame
        stray(5);
        fill(9);
        send("R12 abandoned", 10, 0);
        fill(10); pk[6] = 8'h11; pk[7] = 8'h11;
        send("R12 restart after abandon", 20, 1); idle(2);

        // R2 back-to-back one-byte frames
        fill(11);
        send("R2 single byte a", 1, 1);
        send("R2 single byte b", 1, 1);
        idle(12);

        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R2 missing done: got %0d pending expected 0", exp_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule